// File: doc/BRIEF.md
# Sticky Fault Status Register

This block gathers error events from a memory and bus subsystem into one 64-bit status word. Each event has its own sticky bit, which stays set until software writes a 1 to it. Each event line also has a fixed class: hardware-corrected, software-correctable or uncorrectable. The class decides whether a repeat of the event raises the multiple-error flag and whether the event can request a disrupting trap. Whenever an error is logged, the block also records the privilege level that was in force at that moment.

ECC-type events that arrive during a 64-byte bus transfer pass through a filter. The transfer is presented as a series of 16-byte subunit beats. Only the subunit that first carries an ECC error is logged. ECC errors in later subunits of the same transfer are dropped completely. Software reads the word through a registered read port and clears bits by writing ones. A read never changes the state.

Top module: `fault_status_reg`

## Requirements
- R1: An event strobe on `evt_i[i]` sets status bit 33+i on the next clock edge, and the bit then stays set. With the default map, the event classes are: hardware-corrected for i in {0,3,5,7,13,15}, software-correctable for i = 9, and uncorrectable for every other i in 0..18.
- R2: A write sets to 0 every bit in 51:33 whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged. A read changes no bit.
- R3: Bit 53 (multiple-error flag) sets when a software-correctable or uncorrectable event is accepted while its own status bit is already set.
- R4: A hardware-corrected event whose status bit is already set leaves bit 53 unchanged.
- R5: Several different events that arrive in the same cycle, none of them previously set, each set their own bit and do not set bit 53.
- R6: ECC events are events 0, 1, 12 and 13. A beat with `beat_valid_i` and `beat_first_i` high starts a transfer. Once an ECC event has been accepted in one beat of a transfer, ECC events in all later beats of that transfer are ignored: they set no status bit and do not set bit 53. Non-ECC events are never filtered.
- R7: When any event is accepted, bit 52 takes the value of `priv_i` in that cycle.
- R8: Bit 63 takes `wr_data_i[63]` on every write. No event ever sets it.
- R9: Writing a 1 to bit 53 or to bit 52 clears that bit.
- R10: `trap_o` is high exactly when `irq_en_i` is high and at least one status bit of a hardware-corrected or software-correctable event is set. Uncorrectable bits alone do not raise it.
- R11: After reset every status bit, `rd_data_o` and `trap_o` are 0.
- R12: When an event sets a bit in the same cycle that a write clears it, the bit ends up set. The same holds for bit 53.
- R13: One cycle after `rd_en_i`, `rd_data_o` shows the status word as it was in the cycle `rd_en_i` was high. Bits 62:54 and 32:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 19 | Error event strobes, one per status bit |
| priv_i | input | 1 | Current privilege level |
| beat_valid_i | input | 1 | A 16-byte subunit of a bus transfer is present |
| beat_first_i | input | 1 | This beat is the first subunit of a new transfer |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 64 | Write data (ones clear sticky bits, bit 63 is loaded) |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 64 | Registered read data |
| status_o | output | 64 | Live status word |
| irq_en_i | input | 1 | Interrupt enable |
| trap_o | output | 1 | Disrupting-trap request |

## Verification
Event strobes, filter decisions, writes and privilege capture all show up in `status_o` one clock edge after the cycle they are presented in. `trap_o` follows the registered state and `irq_en_i` with no further delay. `rd_data_o` shows the word that was present in the cycle of `rd_en_i`, one edge later. The bench drives its inputs after each rising edge and, just after that edge, pushes the expected word, trap and read data into a queue. The monitor pops and compares each item two nanoseconds later, while the inputs are still held stable, so each result is checked in the cycle it becomes due.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        CLS_HC = 2'd0,
        CLS_SC = 2'd1,
        CLS_UC = 2'd2
    } err_class_e;

    localparam int FSR_EVT_DEF = 19;

    function automatic logic [2*FSR_EVT_DEF-1:0] default_class_map();
        logic [2*FSR_EVT_DEF-1:0] m;
        m = '0;
        for (int i = 0; i < FSR_EVT_DEF; i++) begin
            case (i)
                0, 3, 5, 7, 13, 15: m[2*i +: 2] = CLS_HC;
                9:                  m[2*i +: 2] = CLS_SC;
                default:            m[2*i +: 2] = CLS_UC;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/fsr_ecc_gate.sv
module fsr_ecc_gate #(
    parameter int                N_EVT    = 19,
    parameter logic [N_EVT-1:0]  ECC_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_i,
    input  logic             beat_valid_i,
    input  logic             beat_first_i,
    output logic [N_EVT-1:0] evt_ok_o
);

    typedef struct packed {
        logic seen;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        block_ecc;
    logic        ecc_now;

    always_comb begin
        st_d      = st_q;
        // later subunits of a transfer that already logged an ECC error
        block_ecc = beat_valid_i && !beat_first_i && st_q.seen;
        evt_ok_o  = block_ecc ? (evt_i & ~ECC_MASK) : evt_i;
        ecc_now   = |(evt_ok_o & ECC_MASK);
        if (beat_valid_i) begin
            if (beat_first_i) begin
                st_d.seen = ecc_now;
            end else begin
                st_d.seen = st_q.seen | ecc_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fsr_sticky_bank.sv
module fsr_sticky_bank
    import fsr_pkg::*;
#(
    parameter int                  N_EVT     = 19,
    parameter logic [2*N_EVT-1:0]  CLASS_MAP = '0
) (
    input  logic [N_EVT-1:0] evt_ok_i,
    input  logic [N_EVT-1:0] sticky_q_i,
    input  logic [N_EVT-1:0] clr_i,
    output logic [N_EVT-1:0] sticky_d_o,
    output logic             repeat_o
);

    logic [N_EVT-1:0] rep_vec;

    for (genvar i = 0; i < N_EVT; i++) begin : g_bit
        localparam logic [1:0] CLS     = CLASS_MAP[2*i +: 2];
        localparam bit         COUNTS  = (CLS != CLS_HC);
        always_comb begin
            // a new detection overrides a same-cycle clear
            sticky_d_o[i] = (sticky_q_i[i] & ~clr_i[i]) | evt_ok_i[i];
            rep_vec[i]    = COUNTS && evt_ok_i[i] && sticky_q_i[i];
        end
    end

    assign repeat_o = |rep_vec;

endmodule

// File: rtl/fsr_trap_gen.sv
module fsr_trap_gen #(
    parameter int                  N_EVT        = 19,
    parameter logic [2*N_EVT-1:0]  CLASS_MAP    = '0,
    parameter logic [2:0]          TRAP_CLASSES = 3'b011
) (
    input  logic [N_EVT-1:0] sticky_q_i,
    input  logic             irq_en_i,
    output logic             trap_o
);

    logic [N_EVT-1:0] trap_mask;

    for (genvar i = 0; i < N_EVT; i++) begin : g_mask
        localparam logic [1:0] CLS = CLASS_MAP[2*i +: 2];
        assign trap_mask[i] = (CLS < 2'd3) ? TRAP_CLASSES[CLS] : 1'b0;
    end

    assign trap_o = irq_en_i && |(sticky_q_i & trap_mask);

endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
    import fsr_pkg::*;
#(
    parameter int                  N_EVT        = 19,
    parameter int                  REG_W        = 64,
    parameter int                  EVT_LSB      = 33,
    parameter int                  PRIV_BIT     = 52,
    parameter int                  ME_BIT       = 53,
    parameter int                  SWF_BIT      = 63,
    parameter logic [2*N_EVT-1:0]  CLASS_MAP    = default_class_map(),
    parameter logic [N_EVT-1:0]    ECC_MASK     = 19'h03003,
    parameter logic [2:0]          TRAP_CLASSES = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              priv_i,
    input  logic              beat_valid_i,
    input  logic              beat_first_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              rd_en_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic [REG_W-1:0]  status_o,
    input  logic              irq_en_i,
    output logic              trap_o
);

    typedef struct packed {
        logic             swf;
        logic             me;
        logic             priv;
        logic [N_EVT-1:0] sticky;
        logic [REG_W-1:0] rd;
    } fsr_state_t;

    fsr_state_t       st_d, st_q;
    logic [N_EVT-1:0] evt_ok;
    logic [N_EVT-1:0] sticky_next;
    logic [N_EVT-1:0] clr_evt;
    logic [REG_W-1:0] clr_all;
    logic             repeat_hit;
    logic             unused_wdata;

    assign unused_wdata = ^wr_data_i;
    assign clr_all      = wr_en_i ? wr_data_i : '0;
    assign clr_evt      = clr_all[EVT_LSB +: N_EVT];

    fsr_ecc_gate #(
        .N_EVT    (N_EVT),
        .ECC_MASK (ECC_MASK)
    ) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .beat_valid_i (beat_valid_i),
        .beat_first_i (beat_first_i),
        .evt_ok_o     (evt_ok)
    );

    fsr_sticky_bank #(
        .N_EVT     (N_EVT),
        .CLASS_MAP (CLASS_MAP)
    ) u_bank (
        .evt_ok_i   (evt_ok),
        .sticky_q_i (st_q.sticky),
        .clr_i      (clr_evt),
        .sticky_d_o (sticky_next),
        .repeat_o   (repeat_hit)
    );

    fsr_trap_gen #(
        .N_EVT        (N_EVT),
        .CLASS_MAP    (CLASS_MAP),
        .TRAP_CLASSES (TRAP_CLASSES)
    ) u_trap (
        .sticky_q_i (st_q.sticky),
        .irq_en_i   (irq_en_i),
        .trap_o     (trap_o)
    );

    // assemble the visible word from the stored fields
    always_comb begin
        status_o                      = '0;
        status_o[SWF_BIT]             = st_q.swf;
        status_o[ME_BIT]              = st_q.me;
        status_o[PRIV_BIT]            = st_q.priv;
        status_o[EVT_LSB +: N_EVT]    = st_q.sticky;
    end

    always_comb begin
        st_d        = st_q;
        st_d.sticky = sticky_next;
        st_d.me     = (st_q.me & ~clr_all[ME_BIT]) | repeat_hit;
        if (|evt_ok) begin
            st_d.priv = priv_i;
        end else begin
            st_d.priv = st_q.priv & ~clr_all[PRIV_BIT];
        end
        if (wr_en_i) begin
            st_d.swf = wr_data_i[SWF_BIT];
        end
        if (rd_en_i) begin
            st_d.rd = status_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rd;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
#(
    parameter int                  N_EVT     = 19,
    parameter int                  REG_W     = 64,
    parameter int                  EVT_LSB   = 33,
    parameter int                  ME_BIT    = 53,
    parameter int                  SWF_BIT   = 63,
    parameter logic [2*N_EVT-1:0]  CLASS_MAP = '0,
    parameter logic [N_EVT-1:0]    ECC_MASK  = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_EVT-1:0] evt_i,
    input logic             wr_en_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic             rd_en_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic [REG_W-1:0] status_o,
    input logic             irq_en_i,
    input logic             trap_o
);

    logic [N_EVT-1:0] counts_mask;
    logic [REG_W-1:0] hold_mask;

    for (genvar i = 0; i < N_EVT; i++) begin : g_cls
        localparam logic [1:0] CLS = CLASS_MAP[2*i +: 2];
        assign counts_mask[i] = (CLS != CLS_HC);
    end

    always_comb begin
        hold_mask                   = '0;
        hold_mask[ME_BIT]           = 1'b1;
        hold_mask[EVT_LSB +: N_EVT] = '1;
    end

    // R8
    swf_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[SWF_BIT]) |-> $past(wr_en_i && wr_data_i[SWF_BIT]));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status_o) & ~status_o) & hold_mask &
          ~($past(wr_en_i) ? $past(wr_data_i) : '0)) == '0));

    // R12
    direct_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & ~ECC_MASK)) |=>
        (($past(evt_i) & ~ECC_MASK & ~status_o[EVT_LSB +: N_EVT]) == '0));

    // R3
    me_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[ME_BIT]) |->
        $past(|(evt_i & status_o[EVT_LSB +: N_EVT] & counts_mask)));

    // R10
    trap_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !trap_o);

    // R10
    trap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (|status_o[EVT_LSB +: N_EVT]));

    // R13
    rd_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> (rd_data_o == $past(status_o)));

endmodule

bind fault_status_reg fsr_checker #(
    .N_EVT     (N_EVT),
    .REG_W     (REG_W),
    .EVT_LSB   (EVT_LSB),
    .ME_BIT    (ME_BIT),
    .SWF_BIT   (SWF_BIT),
    .CLASS_MAP (CLASS_MAP),
    .ECC_MASK  (ECC_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .status_o  (status_o),
    .irq_en_i  (irq_en_i),
    .trap_o    (trap_o)
);

// File: tb/tb_fault_status_reg.sv
module tb_fault_status_reg;

    localparam logic [18:0] HC_M   = 19'h0A0A9;
    localparam logic [18:0] SC_M   = 19'h00200;
    localparam logic [18:0] ECC_M  = 19'h03003;
    localparam logic [18:0] TRAP_M = HC_M | SC_M;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] evt = '0;
    logic        priv = 1'b0, bv = 1'b0, bf = 1'b0, wr = 1'b0, rd = 1'b0, ie = 1'b0;
    logic [63:0] wd = '0;
    logic [63:0] rd_data, status;
    logic        trap;

    always #2 clk = ~clk;

    fault_status_reg dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .priv_i(priv),
        .beat_valid_i(bv), .beat_first_i(bf), .wr_en_i(wr), .wr_data_i(wd),
        .rd_en_i(rd), .rd_data_o(rd_data), .status_o(status),
        .irq_en_i(ie), .trap_o(trap)
    );

    typedef struct {
        logic [63:0] st;
        logic        trap;
        logic [63:0] rdv;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0, failures = 0;
    bit          done = 0;
    logic [63:0] m = '0, m_rd = '0;
    logic        m_seen = 1'b0;

    // expected next state, written from the requirements
    task automatic model_step();
        logic [18:0] acc, stk, clr;
        logic        rep;
        acc = evt;
        if (bv && !bf && m_seen) acc = evt & ~ECC_M;              // R6
        if (bv) m_seen = bf ? |(acc & ECC_M) : (m_seen | |(acc & ECC_M));
        stk = m[51:33];
        clr = wr ? wd[51:33] : '0;
        rep = |(acc & stk & ~HC_M);                              // R3 R4
        if (rd) m_rd = m;                                        // R13
        m[51:33] = (stk & ~clr) | acc;                           // R1 R2 R12
        m[53]    = (m[53] & ~(wr & wd[53])) | rep;               // R9 R12
        m[52]    = (|acc) ? priv : (m[52] & ~(wr & wd[52]));     // R7 R9
        if (wr) m[63] = wd[63];                                  // R8
    endtask

    task automatic step(input logic [18:0] e, input logic p, input logic v,
                        input logic f, input logic w, input logic [63:0] d,
                        input logic r, input logic en, input string tag);
        exp_t it;
        evt = e; priv = p; bv = v; bf = f; wr = w; wd = d; rd = r; ie = en;
        @(posedge clk);
        #1;
        model_step();
        it.st   = m;
        it.trap = ie & |(m[51:33] & TRAP_M);
        it.rdv  = m_rd;
        it.tag  = tag;
        q.push_back(it);
        #2;
    endtask

    function automatic logic [18:0] ev(input int i);
        return 19'(1) << i;
    endfunction

    function automatic logic [63:0] sb(input int i);
        return 64'(1) << i;
    endfunction

    // monitor: compares the oldest expected item once it is due
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                checks++;
                if (status !== it.st || trap !== it.trap || rd_data !== it.rdv) begin
                    failures++;
                    $display("FAIL %s: status=%h trap=%b rd=%h expected status=%h trap=%b rd=%h",
                             it.tag, status, trap, rd_data, it.st, it.trap, it.rdv);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        rst_n = 1'b1;
        step('0, 0, 0, 0, 0, '0, 0, 0, "R11 reset");
        step(ev(0), 1, 0, 0, 0, '0, 0, 1, "R1 R7 R10 first HC");
        step(ev(0), 1, 0, 0, 0, '0, 0, 1, "R4 HC repeat");
        step(ev(1), 0, 0, 0, 0, '0, 0, 1, "R1 R7 UC set");
        step(ev(1), 1, 0, 0, 0, '0, 0, 1, "R3 UC repeat");
        step('0, 0, 0, 0, 1, sb(53) | sb(52), 0, 1, "R9 clear ME PRIV");
        step(ev(9), 0, 0, 0, 0, '0, 0, 1, "R1 SC set");
        step(ev(9), 0, 0, 0, 0, '0, 0, 1, "R3 SC repeat");
        step('0, 0, 0, 0, 1, sb(53), 0, 1, "R9 clear ME");
        step(ev(2) | ev(4), 0, 0, 0, 0, '0, 0, 1, "R5 distinct");
        step('0, 0, 0, 0, 1, 64'h0, 1, 1, "R2 zero write and read");
        step('0, 0, 0, 0, 0, '0, 0, 1, "R13 read data");
        step('0, 0, 0, 0, 1, sb(34), 0, 1, "R2 clear one");
        step('0, 0, 0, 0, 1, sb(63), 0, 1, "R8 set flag");
        step(ev(6), 0, 0, 0, 0, '0, 1, 1, "R8 hold flag");
        step('0, 0, 0, 0, 1, '0, 0, 1, "R8 clear flag R13");
        step(ev(2), 1, 0, 0, 1, sb(35) | sb(53), 0, 1, "R12 collision");
        step('0, 0, 0, 0, 0, '0, 0, 0, "R10 enable low");
        step('0, 0, 0, 0, 1, 64'h003F_FFFE_0000_0000, 0, 1, "R2 clear all");
        step(ev(4), 0, 0, 0, 0, '0, 0, 1, "R10 UC no trap");
        step('0, 0, 0, 0, 1, 64'h003F_FFFE_0000_0000, 0, 1, "R2 clear all");
        step(ev(1), 0, 1, 1, 0, '0, 0, 1, "R6 first subunit");
        step(ev(0), 0, 1, 0, 0, '0, 0, 1, "R6 later ignored");
        step(ev(1), 0, 1, 0, 0, '0, 0, 1, "R6 no ME later");
        step(ev(10), 1, 1, 0, 0, '0, 0, 1, "R6 non ECC passes");
        step(ev(0), 0, 1, 1, 0, '0, 0, 1, "R6 new transfer");
        step('0, 0, 0, 0, 1, 64'h003F_FFFE_0000_0000, 0, 1, "R2 clear all");
        step('0, 0, 1, 1, 0, '0, 0, 1, "R6 clean first beat");
        step(ev(0) | ev(13), 1, 1, 0, 0, '0, 0, 1, "R6 two in one subunit");
        step(ev(12), 0, 1, 0, 0, '0, 0, 1, "R6 R7 blocked no capture");
        step(ev(5), 0, 0, 0, 0, '0, 1, 1, "R7 capture low");
        step('0, 0, 0, 0, 0, '0, 0, 1, "R13 final read");
        step('0, 0, 0, 0, 0, '0, 0, 1, "R2 idle");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule